// File: doc/BRIEF.md
# Redundant reference clock failover controller

This block watches two reference clock inputs and passes one of them to its clock output. It runs entirely on a fast free-running system clock and oversamples both references. When a reference shows no edge for one nominal reference period, it counts as stuck. Each reference has its own latched, active-low failure flag. A one-bit indicator shows which reference is currently requested.

There are two switching modes. In manual mode the select input alone chooses the reference. In automatic mode a latched failure of the requested reference moves the request to the other reference, but only if that one is still alive. A bypass input forces manual behaviour whatever the mode input says.

Flags are cleared only by a falling edge on the alarm-clear input. That edge produces a single internal pulse, so holding the input low does not keep the flags clear. The output mux changes source only on a falling edge of the newly requested reference, which keeps partial high pulses off the output.

Top module: `refclk_failover`

## Requirements
- R1: A reference input that shows no level change for TIMEOUT system clock cycles gets its flag driven low. `fail_n[0]` belongs to `ref_in[0]` and `fail_n[1]` to `ref_in[1]`. A value of 0 means failed.
- R2: A reference that toggles with a half period well under TIMEOUT cycles is never flagged.
- R3: A flag that has gone low stays low until an alarm clear, even if its reference recovers.
- R4: A falling edge on `alarm_clr_n` produces a single internal pulse. That pulse sets both flags to 1, loads `sel_ind` from `sel`, and restarts both stuck counters. Holding `alarm_clr_n` low afterwards clears nothing more, so a still-dead input is flagged again one TIMEOUT later.
- R5: While both flags are low, `sel_ind` is 0, meaning `ref_in[0]`.
- R6: In manual mode (`auto_en` = 0), `sel_ind` follows `sel` (0 selects `ref_in[0]`, 1 selects `ref_in[1]`). Flags still latch in this mode.
- R7: In automatic mode (`auto_en` = 1) with no flag low, `sel_ind` follows `sel`. If the flag of the currently indicated input goes low and the other input is not stuck, `sel_ind` changes to the other input.
- R8: `bypass` = 1 forces manual behaviour even when `auto_en` = 1.
- R9: `ref_out` is the synchronized level of the active reference, registered once. The active source changes only in a cycle where the newly requested reference has just fallen. `ref_out` is static while both references are stuck.
- R10: After an alarm clear, a reference that failed and has recovered can be selected again.
- R11: After reset, `fail_n` = 2'b11, `sel_ind` = 0 and `ref_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock, much faster than the references |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 2 | The two asynchronous reference clocks |
| sel | input | 1 | Preferred reference (0 or 1) |
| auto_en | input | 1 | 1 enables automatic failover |
| bypass | input | 1 | 1 forces manual behaviour |
| alarm_clr_n | input | 1 | Falling edge clears the flags (one-shot) |
| ref_out | output | 1 | Selected reference, sampled in the system clock domain |
| fail_n | output | 2 | Latched active-low failure flags, one per reference |
| sel_ind | output | 1 | Reference currently requested |

## Verification
Two functions can act in the same cycle: the alarm-clear pulse and a fresh stuck detection on an input that is still dead. The bench provokes this by dropping the clear input while a reference is stopped. It checks that the flags read all ones a few cycles after the edge, which shows the clear won and restarted the counter. With the clear input still held low, it then checks that the flag drops again after one TIMEOUT. The same overlap appears with both references dead, where the indicator must settle on input 0.

// File: rtl/refclk_failover_pkg.sv
// Shared constants and types for the reference clock failover controller.
// Assumes exactly two reference inputs; index 0 is the default reference.
package refclk_failover_pkg;

    localparam int NREF = 2;

    // Order of the control inputs inside the synchronizer bundle.
    typedef struct packed {
        logic       bypass;
        logic       auto_en;
        logic       sel;
        logic       clr_n;
        logic [1:0] refs;
    } ctl_bundle_t;

    localparam int CTL_W = $bits(ctl_bundle_t);

endpackage

// File: rtl/fov_sync2.sv
// Two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes every bit is sampled on its own; no bus coherency is implied.
module fov_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/fov_stuck_mon.sv
// Stuck detector for one synchronized reference.
// A counter clears on every level change and saturates at TIMEOUT.
// At TIMEOUT the input is reported dead. A restart clears the counter.
// Also reports a falling edge of the synchronized level.
module fov_stuck_mon #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic lvl,
    output logic dead,
    output logic fall
);

    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic          prev;
    logic [CW-1:0] cnt;

    // Track the previous level and the cycles since the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            cnt  <= '0;
        end else begin
            prev <= lvl;
            if (restart || (lvl != prev))
                cnt <= '0;
            else if (cnt != LIMIT)
                cnt <= cnt + 1'b1;
        end
    end

    assign dead = (cnt == LIMIT);
    assign fall = prev & ~lvl;

endmodule

// File: rtl/fov_sel_ctrl.sv
// Failure flag latches and requested-reference decision.
// Assumes synchronized inputs and a single-cycle clear pulse.
module fov_sel_ctrl
    import refclk_failover_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_pulse,
    input  logic            sel_s,
    input  logic            manual,
    input  logic [NREF-1:0] dead,
    output logic [NREF-1:0] fail_n,
    output logic            tgt
);

    // One latched active-low flag per reference.
    for (genvar i = 0; i < NREF; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                fail_n[i] <= 1'b1;
            else if (clr_pulse)
                fail_n[i] <= 1'b1;
            else if (dead[i])
                fail_n[i] <= 1'b0;
        end
    end

    logic other_ok;
    assign other_ok = ~dead[~tgt];

    // Decide which reference is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tgt <= 1'b0;
        else if (clr_pulse)
            tgt <= sel_s;
        else if (fail_n == '0)
            tgt <= 1'b0;
        else if (manual || (fail_n == '1))
            tgt <= sel_s;
        else if (!fail_n[tgt] && other_ok)
            tgt <= ~tgt;
    end

endmodule

// File: rtl/fov_clk_switch.sv
// Clock source switch in the system clock domain.
// Adopts a new source only when that source has just fallen.
// Assumes the levels come from synchronizers.
module fov_clk_switch
    import refclk_failover_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tgt,
    input  logic [NREF-1:0] lvl,
    input  logic [NREF-1:0] fall,
    output logic            act,
    output logic            ref_out
);

    // Move to the requested source on its falling edge; register the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= 1'b0;
            ref_out <= 1'b0;
        end else begin
            if ((act != tgt) && fall[tgt])
                act <= tgt;
            ref_out <= lvl[act];
        end
    end

endmodule

// File: rtl/refclk_failover.sv
// Top level of the redundant reference clock failover controller.
// Assumes the system clock is several times faster than either reference.
// Set TIMEOUT to one nominal reference period in system clock cycles.
module refclk_failover
    import refclk_failover_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ref_in,
    input  logic       sel,
    input  logic       auto_en,
    input  logic       bypass,
    input  logic       alarm_clr_n,
    output logic       ref_out,
    output logic [1:0] fail_n,
    output logic       sel_ind
);

    ctl_bundle_t raw, syn;
    logic [CTL_W-1:0] syn_bits;

    assign raw = '{bypass: bypass, auto_en: auto_en, sel: sel,
                   clr_n: alarm_clr_n, refs: ref_in};

    fov_sync2 #(.W(CTL_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn_bits)
    );
    assign syn = ctl_bundle_t'(syn_bits);

    logic clr_q, clr_pulse, sel_s, manual;

    // Remember the synchronized clear level to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= syn.clr_n;
    end

    assign clr_pulse = clr_q & ~syn.clr_n;
    assign sel_s     = syn.sel;
    assign manual    = ~syn.auto_en | syn.bypass;

    logic [NREF-1:0] lvl, dead, fall;
    assign lvl = syn.refs;

    for (genvar i = 0; i < NREF; i++) begin : g_mon
        fov_stuck_mon #(.TIMEOUT(TIMEOUT)) u_mon (
            .clk(clk), .rst_n(rst_n), .restart(clr_pulse),
            .lvl(lvl[i]), .dead(dead[i]), .fall(fall[i])
        );
    end

    logic tgt, act;

    fov_sel_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr_pulse(clr_pulse), .sel_s(sel_s),
        .manual(manual), .dead(dead), .fail_n(fail_n), .tgt(tgt)
    );

    fov_clk_switch u_sw (
        .clk(clk), .rst_n(rst_n), .tgt(tgt), .lvl(lvl), .fall(fall),
        .act(act), .ref_out(ref_out)
    );

    assign sel_ind = tgt;

endmodule

// File: rtl/refclk_failover_chk.sv
// Property checker for refclk_failover, attached with bind.
module refclk_failover_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_pulse,
    input logic       manual,
    input logic       sel_s,
    input logic [1:0] dead,
    input logic [1:0] fail_n,
    input logic       tgt,
    input logic       act,
    input logic [1:0] lvl
);

    logic       act_q;
    logic [1:0] lvl_q;

    // Local history for the switch-point property.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            lvl_q <= 2'b00;
        end else begin
            act_q <= act;
            lvl_q <= lvl;
        end
    end

    a_r1_drop_needs_dead0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail_n[0]) |-> $past(dead[0]));
    a_r1_drop_needs_dead1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail_n[1]) |-> $past(dead[1]));
    a_r3_hold0: assert property (@(posedge clk) disable iff (!rst_n)
        (!fail_n[0] && !clr_pulse) |=> !fail_n[0]);
    a_r3_hold1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fail_n[1] && !clr_pulse) |=> !fail_n[1]);
    a_r4_clear_sets: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> (fail_n == 2'b11));
    a_r5_dual_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_n == 2'b00 && !clr_pulse) |=> !tgt);
    a_r6_manual_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (manual && !clr_pulse && fail_n != 2'b00) |=> (tgt == $past(sel_s)));
    a_r9_switch_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (act != act_q) |-> (lvl_q[act] == 1'b0));

endmodule

bind refclk_failover refclk_failover_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clr_pulse(clr_pulse), .manual(manual),
    .sel_s(sel_s), .dead(dead), .fail_n(fail_n), .tgt(tgt), .act(act),
    .lvl(lvl)
);

// File: tb/sim_refclk_failover.sv
module sim_refclk_failover;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic mode = 1'b0, byp = 1'b0, sel = 1'b0, clr_n = 1'b1;
    logic run0 = 1'b1, run1 = 1'b1, r0 = 1'b0, r1 = 1'b0;
    logic       ref_out, sel_ind;
    logic [1:0] fail_n;

    // Reference clocks: 160 ns period, 16 system cycles; ref 1 offset by 40 ns.
    initial forever begin #80; if (run0) r0 = ~r0; end
    initial begin #40; forever begin #80; if (run1) r1 = ~r1; end end

    refclk_failover #(.TIMEOUT(16)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_in({r1, r0}), .sel(sel),
        .auto_en(mode), .bypass(byp), .alarm_clr_n(clr_n),
        .ref_out(ref_out), .fail_n(fail_n), .sel_ind(sel_ind)
    );

    int nchk = 0, nbad = 0;

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Fields: [8]auto [7]bypass [6]sel [5]run0 [4]run1 [3]clear [2:1]fail_n [0]sel_ind
    localparam logic [8:0] VEC [0:16] = '{
        9'b0_0_0_1_1_0_11_0,  // R6 manual sel 0
        9'b0_0_1_1_1_0_11_1,  // R6 manual sel 1, R2 healthy
        9'b1_0_0_1_1_0_11_0,  // R7 auto, no flag
        9'b1_0_0_0_1_0_10_1,  // R1 R7 failover to ref 1
        9'b1_0_0_1_1_0_10_1,  // R3 flag held after recovery
        9'b1_0_0_1_1_1_11_0,  // R4 R10 clear, back to ref 0
        9'b1_0_1_1_0_0_01_0,  // R7 failover to ref 0
        9'b1_0_1_1_0_1_01_0,  // R4 clear while ref 1 dead
        9'b1_1_1_1_1_0_01_1,  // R8 bypass forces manual
        9'b0_0_0_0_0_0_00_0,  // R6 R5 both dead in manual
        9'b0_0_1_0_0_1_00_0,  // R5 clear with both dead
        9'b1_0_1_1_1_1_11_1,  // R10 both back, clear
        9'b1_0_1_0_1_0_10_1,  // R7 secondary fails, no switch
        9'b1_0_1_0_0_0_00_0,  // R5 both fail in auto
        9'b1_0_0_1_1_0_00_0,  // R3 latched after recovery
        9'b1_0_0_1_1_1_11_0,  // R4 clear
        9'b0_0_1_1_1_0_11_1   // R6 manual sel 1
    };

    task automatic pulse_clear();
        clr_n = 1'b0;
        repeat (4) @(negedge clk);
        clr_n = 1'b1;
    endtask

    initial begin : watchdog
        #200000;
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin : main
        int tog, run, minlow;
        logic prev, seen;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 fail_n", {2'b0, fail_n}, 4'h3);
        chk("R11 sel_ind", {3'b0, sel_ind}, 4'h0);
        chk("R11 ref_out", {3'b0, ref_out}, 4'h0);

        for (int i = 0; i < 17; i++) begin
            @(negedge clk);
            mode = VEC[i][8]; byp = VEC[i][7]; sel = VEC[i][6];
            run0 = VEC[i][5]; run1 = VEC[i][4];
            if (VEC[i][3]) pulse_clear();
            repeat (90) @(negedge clk);
            chk($sformatf("R1 R3 R5 R6 R7 R8 R10 vec %0d fail_n", i),
                {2'b0, fail_n}, {2'b0, VEC[i][2:1]});
            chk($sformatf("R5 R6 R7 R8 R10 vec %0d sel_ind", i),
                {3'b0, sel_ind}, {3'b0, VEC[i][0]});
        end

        // R4: the clear coincides with a dead input and is one-shot.
        mode = 1'b0; sel = 1'b0; run0 = 1'b0;
        repeat (90) @(negedge clk);
        chk("R1 ref 0 flagged", {2'b0, fail_n}, 4'h2);
        clr_n = 1'b0;
        repeat (10) @(negedge clk);
        chk("R4 clear wins", {2'b0, fail_n}, 4'h3);
        repeat (60) @(negedge clk);
        chk("R4 one-shot relatch", {2'b0, fail_n}, 4'h2);
        chk("R4 R6 sel_ind", {3'b0, sel_ind}, 4'h0);
        clr_n = 1'b1;

        // R9: manual switch with both running; no short low pulse, output toggles.
        run0 = 1'b1;
        repeat (20) @(negedge clk);
        pulse_clear();
        repeat (60) @(negedge clk);
        sel = 1'b1;
        tog = 0; run = 0; minlow = 99; seen = 1'b0; prev = ref_out;
        for (int c = 0; c < 120; c++) begin
            @(negedge clk);
            if (ref_out != prev) tog++;
            if (ref_out && !prev) begin
                if (seen && run < minlow) minlow = run;
                seen = 1'b1;
            end
            run  = ref_out ? 0 : run + 1;
            prev = ref_out;
        end
        chk("R9 output toggles", {3'b0, (tog >= 8)}, 4'h1);
        chk("R9 low pulses not cut", {3'b0, (minlow >= 6)}, 4'h1);
        chk("R6 sel_ind after switch", {3'b0, sel_ind}, 4'h1);

        // R9: both stuck, output static.
        run0 = 1'b0; run1 = 1'b0;
        repeat (40) @(negedge clk);
        tog = 0; prev = ref_out;
        for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            if (ref_out != prev) tog++;
            prev = ref_out;
        end
        chk("R9 static when both dead", tog[3:0], 4'h0);
        chk("R5 sel_ind both dead", {3'b0, sel_ind}, 4'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule